// File: doc/BRIEF.md
# Processor Debug Control Unit

This block is the debug controller of a small 32-bit core. An external debugger reaches it through a simple slave port. The port has request, write-enable, a 15-bit byte address, 32-bit write data, and grant, read-valid and 32-bit read-data outputs. Through this port the debugger can stop and restart the core and arm single-stepping. It can choose which exceptions divert into debug mode, read why the core stopped, and read or redirect the program counters. While the core is stopped, the debugger can also reach the core's general-purpose and control/status registers.

The core itself is not part of the block. The pipeline reports what happens on a handful of inputs:
- instruction retire, with its PC and the next sequential PC;
- an exception, with its cause, faulting PC and the trap vector;
- an interrupt, with its number;
- a sleep flag.

Register and CSR accesses are forwarded on a one-cycle request port. That port is answered combinationally. Two pulse inputs let neighbouring cores stop or restart this one for cross-triggering. A halted flag goes back out to them.

Top module: `dbg_ctl_unit`

## Requirements
- R1: Every request is granted in the same cycle. `rvalid_o` is high exactly one cycle after each granted access and low otherwise. `rdata_o` carries the read result in that cycle, and zero after a write.
- R2: Control word at byte address 0x00. Bit 16 reads 1 while halted. Writing bit 16 = 1 while running halts the core (`halted_o` high from the next cycle). Writing bit 16 = 0 while halted resumes it. Bit 0 is a read/write step-enable, and the value written in the same word is the one applied to that resume.
- R3: A one-cycle `ext_halt_i` pulse halts a running core. A one-cycle `ext_resume_i` pulse resumes a halted one. Each has no effect in the other state.
- R4: Status word at 0x04. Bit 16 mirrors `sleep_i`. Bit 0 is set when a single step completes and stays set until a write with bit 0 = 0. A write with bit 0 = 1 leaves it unchanged.
- R5: Trap-enable word at 0x08. Only bits 0–7 and 11 are writable; all other bits read 0. An exception with cause code c enters debug mode only when bit c is set. Cause 3 is breakpoint, 2 is illegal and 11 is environment call. Otherwise the exception leaves the core running.
- R6: Reason word at 0x0C, read-only. Bit 31 is 1 when an interrupt caused entry. Bits 4:0 hold the exception or interrupt number. A halt request or a completed step records 0.
- R7: On entry the PC pair is captured as follows:
  - Breakpoint: previous PC = faulting PC, next PC = faulting PC + 4.
  - Other enabled exception: previous PC = faulting PC, next PC = vector.
  - Interrupt: previous PC = last retired PC, next PC = vector.
  - Halt: previous PC = last retired PC, next PC = `next_pc_i`.
- R8: While halted, the previous PC reads at 0x2004 and the next PC at 0x2000. A write to 0x2000 while halted replaces the next PC. It also pulses `jump_o` for one cycle in the following cycle, with `jump_pc_o` equal to the written value.
- R9: While halted, address 0x400 + 4n reaches GPR n (`core_sel_o` = 0) and address 0x4000 + 4n reaches CSR n (`core_sel_o` = 1). `core_req_o` is driven in the grant cycle, and a read returns `core_rdata_i`.
- R10: While running, any access to 0x2000–0x20FF, to the GPRs or to the CSRs is still granted. Reads return 0. Writes raise no `core_req_o` and no `jump_o`.
- R11: A resume with step-enable set lets exactly one instruction retire. The core then re-enters debug mode with previous PC = that instruction and next PC = `next_pc_i`. A resume with step-enable clear does not re-halt on retire.
- R12: The breakpoint words 0x40–0x7C, the floating-point window 0x500–0x5FF, any misaligned address and any unmapped address read 0 and raise no `core_req_o`.
- R13: When entry events coincide, the priority is enabled exception, then interrupt, then step completion, then halt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Bus write enable |
| addr_i | input | 15 | Bus byte address |
| wdata_i | input | 32 | Bus write data |
| gnt_o | output | 1 | Bus grant |
| rvalid_o | output | 1 | Response valid, one cycle after grant |
| rdata_o | output | 32 | Read data |
| halted_o | output | 1 | Core is in debug mode |
| ext_halt_i | input | 1 | Cross-trigger halt pulse |
| ext_resume_i | input | 1 | Cross-trigger resume pulse |
| retire_i | input | 1 | An instruction retired this cycle |
| retire_pc_i | input | 32 | PC of the retiring instruction |
| next_pc_i | input | 32 | PC the core would fetch next |
| exc_i | input | 1 | Exception raised this cycle |
| exc_cause_i | input | 5 | Exception cause code |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| vec_pc_i | input | 32 | Trap vector entry PC |
| irq_i | input | 1 | Interrupt routed to debug this cycle |
| irq_id_i | input | 5 | Interrupt number |
| sleep_i | input | 1 | Core waits for an event |
| core_req_o | output | 1 | Core register access request |
| core_sel_o | output | 1 | 0 = GPR file, 1 = CSR file |
| core_we_o | output | 1 | Core register write |
| core_idx_o | output | 12 | Register index |
| core_wdata_o | output | 32 | Core register write data |
| core_rdata_i | input | 32 | Core register read data, same cycle |
| jump_o | output | 1 | Redirect pulse for the core |
| jump_pc_o | output | 32 | Redirect target |

## Verification
The assertions take for granted that the cross-trigger inputs are single-cycle pulses. They also assume that the core reports no retire while halted, and that `core_rdata_i` settles within the grant cycle. The bench drives every event input for exactly one clock, and drives it only while the core is running. It answers register requests with a combinational model, so the stimulus never leaves these bounds. Apart from the priority test, the bench never raises two entry events in the same cycle, so the capture values for each entry reason can be checked on their own.

// File: rtl/dbg_ctl_pkg.sv
`timescale 1ns/1ps
package dbg_ctl_pkg;
  localparam int DW = 32;
  localparam int AW = 15;
  localparam int IDX_W = 12;
  localparam int CODE_W = 5;

  localparam int HALT_BIT  = 16;
  localparam int STEP_BIT  = 0;
  localparam int SLEEP_BIT = 16;
  localparam int HIT_BIT   = 0;
  localparam int IRQ_BIT   = 31;

  localparam logic [DW-1:0]     TRAP_MASK   = 32'h0000_08FF;
  localparam logic [CODE_W-1:0] CODE_EBREAK = 5'd3;

  typedef enum logic [1:0] {ST_RUN, ST_STEP, ST_HALT} dbg_state_e;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_HIT, RG_TRAP, RG_WHY, RG_BKPT,
    RG_NPC, RG_PPC, RG_GPR, RG_CSR
  } region_e;

  function automatic region_e decode_region(input logic [AW-1:0] a);
    region_e r = RG_NONE;
    if (a[1:0] != 2'b00)        r = RG_NONE;
    else if (a[14])             r = RG_CSR;
    else if (a[13:7] == 7'h08)  r = RG_GPR;
    else if (a[13:7] == 7'h00) begin
      if (a[6])                 r = RG_BKPT;
      else case (a[5:2])
        4'd0: r = RG_CTRL;
        4'd1: r = RG_HIT;
        4'd2: r = RG_TRAP;
        4'd3: r = RG_WHY;
        default: r = RG_NONE;
      endcase
    end
    else if (a == 15'h2000)     r = RG_NPC;
    else if (a == 15'h2004)     r = RG_PPC;
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] core_index(input logic [AW-1:0] a);
    return a[14] ? a[13:2] : {7'd0, a[6:2]};
  endfunction

  function automatic logic needs_halt(input region_e r);
    return (r == RG_NPC) || (r == RG_PPC) || (r == RG_GPR) || (r == RG_CSR);
  endfunction

  function automatic logic trap_enabled(input logic [DW-1:0] en,
                                        input logic [CODE_W-1:0] c);
    return (c < 5'd12) && en[c] && TRAP_MASK[c];
  endfunction

  function automatic logic [DW-1:0] seq_pc(input logic [DW-1:0] pc);
    return pc + 32'd4;
  endfunction
endpackage

// File: rtl/dbg_ctl_decode.sv
`timescale 1ns/1ps
module dbg_ctl_decode
  import dbg_ctl_pkg::*;
#(
  parameter int ADDR_W = AW,
  localparam int IW = IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [IW-1:0]     idx_o,
  output logic              halt_only_o
);
  always_comb begin
    region_o    = decode_region(addr_i);
    idx_o       = core_index(addr_i);
    halt_only_o = needs_halt(region_o);
  end
endmodule

// File: rtl/dbg_ctl_fsm.sv
`timescale 1ns/1ps
module dbg_ctl_fsm
  import dbg_ctl_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CW = CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_req_i,
  input  logic              resume_req_i,
  input  logic              step_en_i,
  input  logic              exc_i,
  input  logic [CW-1:0]     exc_cause_i,
  input  logic              trap_en_i,
  input  logic              irq_i,
  input  logic [CW-1:0]     irq_id_i,
  input  logic              retire_i,
  input  logic [DATA_W-1:0] retire_pc_i,
  input  logic [DATA_W-1:0] exc_pc_i,
  input  logic [DATA_W-1:0] vec_pc_i,
  input  logic [DATA_W-1:0] next_pc_i,
  input  logic              npc_wr_i,
  input  logic [DATA_W-1:0] npc_wdata_i,
  input  logic              hit_clr_i,
  output logic              halted_o,
  output logic [DATA_W-1:0] why_o,
  output logic [DATA_W-1:0] ppc_o,
  output logic [DATA_W-1:0] npc_o,
  output logic              hit_o,
  output logic              enter_o,
  output logic              resume_o,
  output logic              step_done_o
);
  dbg_state_e        state_q;
  logic [DATA_W-1:0] last_pc_q, last_pc_now;
  logic [DATA_W-1:0] why_d, ppc_d, npc_d;
  logic              running, exc_take, irq_take, halt_take;

  always_comb begin
    running     = (state_q != ST_HALT);
    last_pc_now = retire_i ? retire_pc_i : last_pc_q;
    exc_take    = running && exc_i && trap_en_i;
    irq_take    = running && !exc_take && irq_i;
    step_done_o = running && !exc_take && !irq_take && (state_q == ST_STEP) && retire_i;
    halt_take   = running && !exc_take && !irq_take && !step_done_o && halt_req_i;
    enter_o     = exc_take || irq_take || step_done_o || halt_take;
    resume_o    = !running && resume_req_i;
    why_d = '0;
    ppc_d = last_pc_now;
    npc_d = next_pc_i;
    if (exc_take) begin
      why_d[CW-1:0] = exc_cause_i;
      ppc_d = exc_pc_i;
      npc_d = (exc_cause_i == CODE_EBREAK) ? seq_pc(exc_pc_i) : vec_pc_i;
    end else if (irq_take) begin
      why_d[IRQ_BIT]  = 1'b1;
      why_d[CW-1:0]   = irq_id_i;
      npc_d = vec_pc_i;
    end else if (step_done_o) begin
      ppc_d = retire_pc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      last_pc_q <= '0;
      why_o     <= '0;
      ppc_o     <= '0;
      npc_o     <= '0;
      hit_o     <= 1'b0;
    end else begin
      if (retire_i) last_pc_q <= retire_pc_i;
      if (enter_o) begin
        state_q <= ST_HALT;
        why_o   <= why_d;
        ppc_o   <= ppc_d;
        npc_o   <= npc_d;
      end else if (resume_o) begin
        state_q <= step_en_i ? ST_STEP : ST_RUN;
      end else if (!running && npc_wr_i) begin
        npc_o <= npc_wdata_i;
      end
      if (step_done_o)    hit_o <= 1'b1;
      else if (hit_clr_i) hit_o <= 1'b0;
    end
  end

  assign halted_o = !running;
endmodule

// File: rtl/dbg_ctl_unit.sv
`timescale 1ns/1ps
module dbg_ctl_unit
  import dbg_ctl_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int DATA_W = DW,
  localparam int IW = IDX_W,
  localparam int CW = CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              gnt_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              halted_o,
  input  logic              ext_halt_i,
  input  logic              ext_resume_i,
  input  logic              retire_i,
  input  logic [DATA_W-1:0] retire_pc_i,
  input  logic [DATA_W-1:0] next_pc_i,
  input  logic              exc_i,
  input  logic [CW-1:0]     exc_cause_i,
  input  logic [DATA_W-1:0] exc_pc_i,
  input  logic [DATA_W-1:0] vec_pc_i,
  input  logic              irq_i,
  input  logic [CW-1:0]     irq_id_i,
  input  logic              sleep_i,
  output logic              core_req_o,
  output logic              core_sel_o,
  output logic              core_we_o,
  output logic [IW-1:0]     core_idx_o,
  output logic [DATA_W-1:0] core_wdata_o,
  input  logic [DATA_W-1:0] core_rdata_i,
  output logic              jump_o,
  output logic [DATA_W-1:0] jump_pc_o
);
  region_e           region;
  logic [IW-1:0]     idx;
  logic              halt_only, wr, rd, ctrl_wr, step_eff, npc_wr, hit_clr;
  logic              step_q, hit, enter_evt, resume_evt, step_done;
  logic [DATA_W-1:0] trap_q, why, ppc, npc, rd_mux;

  dbg_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .region_o(region), .idx_o(idx), .halt_only_o(halt_only)
  );

  always_comb begin
    wr       = req_i && we_i;
    rd       = req_i && !we_i;
    ctrl_wr  = wr && (region == RG_CTRL);
    step_eff = ctrl_wr ? wdata_i[STEP_BIT] : step_q;
    npc_wr   = wr && (region == RG_NPC) && halted_o;
    hit_clr  = wr && (region == RG_HIT) && !wdata_i[HIT_BIT];
  end

  dbg_ctl_fsm #(.DATA_W(DATA_W), .CW(CW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .halt_req_i((ctrl_wr && wdata_i[HALT_BIT]) || ext_halt_i),
    .resume_req_i((ctrl_wr && !wdata_i[HALT_BIT]) || ext_resume_i),
    .step_en_i(step_eff),
    .exc_i(exc_i), .exc_cause_i(exc_cause_i),
    .trap_en_i(trap_enabled(trap_q, exc_cause_i)),
    .irq_i(irq_i), .irq_id_i(irq_id_i),
    .retire_i(retire_i), .retire_pc_i(retire_pc_i),
    .exc_pc_i(exc_pc_i), .vec_pc_i(vec_pc_i), .next_pc_i(next_pc_i),
    .npc_wr_i(npc_wr), .npc_wdata_i(wdata_i), .hit_clr_i(hit_clr),
    .halted_o(halted_o), .why_o(why), .ppc_o(ppc), .npc_o(npc), .hit_o(hit),
    .enter_o(enter_evt), .resume_o(resume_evt), .step_done_o(step_done)
  );

  // core register window, open only while halted
  always_comb begin
    core_req_o   = req_i && halted_o && ((region == RG_GPR) || (region == RG_CSR));
    core_sel_o   = (region == RG_CSR);
    core_we_o    = we_i;
    core_idx_o   = idx;
    core_wdata_o = wdata_i;
  end

  always_comb begin
    rd_mux = '0;
    if (!halt_only || halted_o) begin
      case (region)
        RG_CTRL: begin rd_mux[HALT_BIT] = halted_o; rd_mux[STEP_BIT] = step_q; end
        RG_HIT:  begin rd_mux[SLEEP_BIT] = sleep_i; rd_mux[HIT_BIT] = hit; end
        RG_TRAP: rd_mux = trap_q;
        RG_WHY:  rd_mux = why;
        RG_NPC:  rd_mux = npc;
        RG_PPC:  rd_mux = ppc;
        RG_GPR, RG_CSR: rd_mux = core_rdata_i;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q    <= 1'b0;
      trap_q    <= '0;
      rvalid_o  <= 1'b0;
      rdata_o   <= '0;
      jump_o    <= 1'b0;
      jump_pc_o <= '0;
    end else begin
      if (ctrl_wr) step_q <= wdata_i[STEP_BIT];
      if (wr && (region == RG_TRAP)) trap_q <= wdata_i & TRAP_MASK;
      rvalid_o <= req_i;
      rdata_o  <= rd ? rd_mux : '0;
      jump_o   <= npc_wr;
      if (npc_wr) jump_pc_o <= wdata_i;
    end
  end

  assign gnt_o = req_i;
endmodule

// File: rtl/dbg_ctl_unit_chk.sv
`timescale 1ns/1ps
module dbg_ctl_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic gnt_o,
  input logic rvalid_o,
  input logic halted_o,
  input logic core_req_o,
  input logic jump_o,
  input logic enter_evt,
  input logic resume_evt,
  input logic step_done
);
  assert_grant_same_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> gnt_o);
  assert_rvalid_after_grant_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && gnt_o) |=> rvalid_o);
  assert_no_spurious_rvalid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rvalid_o);
  assert_halt_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !resume_evt) |=> halted_o);
  assert_run_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !enter_evt) |=> !halted_o);
  assert_jump_only_halted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> halted_o);
  assert_core_access_halted_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_req_o |-> halted_o);
  assert_step_rehalts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done |=> halted_o);
  assert_entry_halts_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_evt |=> halted_o);
  assert_enter_resume_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enter_evt && resume_evt));
endmodule

bind dbg_ctl_unit dbg_ctl_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .gnt_o(gnt_o),
  .rvalid_o(rvalid_o), .halted_o(halted_o), .core_req_o(core_req_o),
  .jump_o(jump_o), .enter_evt(enter_evt), .resume_evt(resume_evt),
  .step_done(step_done)
);

// File: tb/dbg_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_ctl_unit_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [14:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        gnt, rvalid, halted;
  logic [31:0] rdata;
  logic        ext_halt = 0, ext_resume = 0, retire = 0, exc = 0, irq = 0, sleep = 0;
  logic [31:0] retire_pc = '0, next_pc = '0, exc_pc = '0, vec_pc = 32'h80;
  logic [4:0]  exc_cause = '0, irq_id = '0;
  logic        core_req, core_sel, core_we, jump;
  logic [11:0] core_idx;
  logic [31:0] core_wdata, core_rdata, jump_pc;

  int n_chk = 0, n_fail = 0;
  int core_cnt = 0, jump_cnt = 0;
  logic [31:0] last_jump_pc = '0, last_core_wd = '0;
  logic [11:0] last_core_idx = '0;
  logic        last_core_sel = 0;

  always #2 clk = ~clk;

  assign core_rdata = {core_sel ? 8'hC5 : 8'hA0, 12'h000, core_idx};

  dbg_ctl_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata),
    .halted_o(halted), .ext_halt_i(ext_halt), .ext_resume_i(ext_resume),
    .retire_i(retire), .retire_pc_i(retire_pc), .next_pc_i(next_pc),
    .exc_i(exc), .exc_cause_i(exc_cause), .exc_pc_i(exc_pc), .vec_pc_i(vec_pc),
    .irq_i(irq), .irq_id_i(irq_id), .sleep_i(sleep),
    .core_req_o(core_req), .core_sel_o(core_sel), .core_we_o(core_we),
    .core_idx_o(core_idx), .core_wdata_o(core_wdata), .core_rdata_i(core_rdata),
    .jump_o(jump), .jump_pc_o(jump_pc)
  );

  always @(posedge clk) begin
    if (core_req) begin
      core_cnt <= core_cnt + 1;
      if (core_we) begin
        last_core_idx <= core_idx; last_core_wd <= core_wdata; last_core_sel <= core_sel;
      end
    end
    if (jump) begin jump_cnt <= jump_cnt + 1; last_jump_pc <= jump_pc; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [14:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    req = 1; we = w; addr = a; wdata = d;
    #1 chk("R1 grant", {31'd0, gnt}, 32'd1);
    @(negedge clk);
    req = 0; we = 0;
    chk("R1 rvalid", {31'd0, rvalid}, 32'd1);
    r = rdata;
  endtask

  task automatic rd(input string tag, input logic [14:0] a, input logic [31:0] exp);
    logic [31:0] r;
    bus(1'b0, a, '0, r);
    chk(tag, r, exp);
  endtask

  task automatic wr(input logic [14:0] a, input logic [31:0] d);
    logic [31:0] r;
    bus(1'b1, a, d, r);
    chk("R1 write rdata zero", r, 32'd0);
  endtask

  task automatic do_retire(input logic [31:0] pc);
    retire = 1; retire_pc = pc; @(negedge clk); retire = 0;
  endtask

  task automatic do_exc(input logic [4:0] c, input logic [31:0] pc);
    exc = 1; exc_cause = c; exc_pc = pc; @(negedge clk); exc = 0;
  endtask

  task automatic chk_halted(input string tag, input logic exp);
    chk(tag, {31'd0, halted}, {31'd0, exp});
  endtask

  task automatic t_reset;
    chk_halted("R2 reset running", 1'b0);
    chk("R1 reset rvalid", {31'd0, rvalid}, 32'd0);
    rd("R2 reset ctrl", 15'h0000, 32'h0);
    rd("R5 reset trap", 15'h0008, 32'h0);
    rd("R6 reset why", 15'h000C, 32'h0);
  endtask

  task automatic t_bus_halt;
    next_pc = 32'h104;
    do_retire(32'h100);
    wr(15'h0000, 32'h0001_0000);
    chk_halted("R2 halt by write", 1'b1);
    rd("R2 ctrl halted bit", 15'h0000, 32'h0001_0000);
    rd("R7 halt ppc", 15'h2004, 32'h100);
    rd("R7 halt npc", 15'h2000, 32'h104);
    rd("R6 halt why zero", 15'h000C, 32'h0);
  endtask

  task automatic t_core_access;
    int c0 = core_cnt;
    rd("R9 gpr read", 15'h0414, 32'hA000_0005);
    wr(15'h4C00, 32'hDEAD_BEEF);
    chk("R9 csr idx", {20'd0, last_core_idx}, 32'h300);
    chk("R9 csr sel", {31'd0, last_core_sel}, 32'd1);
    chk("R9 csr wdata", last_core_wd, 32'hDEAD_BEEF);
    chk("R9 req count", core_cnt, c0 + 2);
  endtask

  task automatic t_npc_write;
    wr(15'h2000, 32'h800);
    @(negedge clk);
    chk("R8 jump count", jump_cnt, 1);
    chk("R8 jump pc", last_jump_pc, 32'h800);
    rd("R8 npc readback", 15'h2000, 32'h800);
  endtask

  task automatic t_running_gate;
    int c0, j0;
    wr(15'h0000, 32'h0);
    chk_halted("R2 resume by write", 1'b0);
    c0 = core_cnt; j0 = jump_cnt;
    rd("R10 npc hidden", 15'h2000, 32'h0);
    rd("R10 ppc hidden", 15'h2004, 32'h0);
    rd("R10 gpr hidden", 15'h0414, 32'h0);
    wr(15'h2000, 32'h999);
    wr(15'h0414, 32'h1234);
    @(negedge clk);
    chk("R10 no core req", core_cnt, c0);
    chk("R10 no jump", jump_cnt, j0);
    chk_halted("R10 still running", 1'b0);
  endtask

  task automatic t_ext;
    ext_resume = 1; @(negedge clk); ext_resume = 0;
    chk_halted("R3 resume ignored running", 1'b0);
    ext_halt = 1; @(negedge clk); ext_halt = 0;
    chk_halted("R3 ext halt", 1'b1);
    ext_halt = 1; @(negedge clk); ext_halt = 0;
    chk_halted("R3 halt ignored halted", 1'b1);
    ext_resume = 1; @(negedge clk); ext_resume = 0;
    chk_halted("R3 ext resume", 1'b0);
  endtask

  task automatic t_step;
    wr(15'h0000, 32'h0001_0000);
    wr(15'h0000, 32'h0000_0001);
    chk_halted("R11 step resume", 1'b0);
    repeat (3) @(negedge clk);
    chk_halted("R11 no halt before retire", 1'b0);
    next_pc = 32'h204;
    do_retire(32'h200);
    chk_halted("R11 halt after one retire", 1'b1);
    rd("R4 hit set", 15'h0004, 32'h1);
    rd("R11 step ppc", 15'h2004, 32'h200);
    rd("R11 step npc", 15'h2000, 32'h204);
    rd("R6 step why zero", 15'h000C, 32'h0);
    rd("R2 ctrl step bit", 15'h0000, 32'h0001_0001);
    sleep = 1;
    rd("R4 sleep mirror", 15'h0004, 32'h0001_0001);
    wr(15'h0004, 32'h1);
    rd("R4 write one keeps", 15'h0004, 32'h0001_0001);
    wr(15'h0004, 32'h0);
    rd("R4 write zero clears", 15'h0004, 32'h0001_0000);
    sleep = 0;
    wr(15'h0000, 32'h0);
    do_retire(32'h210);
    do_retire(32'h214);
    chk_halted("R11 no step when disabled", 1'b0);
  endtask

  task automatic t_traps;
    wr(15'h0008, 32'hFFFF_FFFF);
    rd("R5 trap writable bits", 15'h0008, 32'h0000_08FF);
    wr(15'h0008, 32'h8);
    do_exc(5'd2, 32'h300);
    chk_halted("R5 masked illegal ignored", 1'b0);
    do_exc(5'd3, 32'h300);
    chk_halted("R5 ebreak traps", 1'b1);
    rd("R6 ebreak why", 15'h000C, 32'h3);
    rd("R7 ebreak ppc", 15'h2004, 32'h300);
    rd("R7 ebreak npc", 15'h2000, 32'h304);
    wr(15'h0000, 32'h0);
    wr(15'h0008, 32'h804);
    do_exc(5'd11, 32'h400);
    chk_halted("R5 ecall traps", 1'b1);
    rd("R6 ecall why", 15'h000C, 32'hB);
    rd("R7 ecall ppc", 15'h2004, 32'h400);
    rd("R7 ecall npc", 15'h2000, 32'h80);
    wr(15'h0000, 32'h0);
  endtask

  task automatic t_irq;
    do_retire(32'h500);
    irq = 1; irq_id = 5'd7; @(negedge clk); irq = 0;
    chk_halted("R6 irq halts", 1'b1);
    rd("R6 irq why", 15'h000C, 32'h8000_0007);
    rd("R7 irq ppc", 15'h2004, 32'h500);
    rd("R7 irq npc", 15'h2000, 32'h80);
    wr(15'h0000, 32'h0);
  endtask

  task automatic t_priority;
    exc = 1; exc_cause = 5'd2; exc_pc = 32'h600;
    irq = 1; irq_id = 5'd9; ext_halt = 1;
    @(negedge clk);
    exc = 0; irq = 0; ext_halt = 0;
    chk_halted("R13 halted", 1'b1);
    rd("R13 exception wins why", 15'h000C, 32'h2);
    rd("R13 exception wins ppc", 15'h2004, 32'h600);
    rd("R13 exception wins npc", 15'h2000, 32'h80);
  endtask

  task automatic t_misc;
    int c0 = core_cnt;
    for (int i = 0; i < 16; i++)
      rd("R12 breakpoint word zero", 15'(15'h40 + 4 * i), 32'h0);
    rd("R12 fp window zero", 15'h0500, 32'h0);
    rd("R12 misaligned zero", 15'h0402, 32'h0);
    rd("R12 unmapped zero", 15'h0010, 32'h0);
    @(negedge clk);
    chk("R12 no core req", core_cnt, c0);
    wr(15'h0000, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bus_halt();
    t_core_access();
    t_npc_write();
    t_running_gate();
    t_ext();
    t_step();
    t_traps();
    t_irq();
    t_priority();
    t_misc();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule